// File: doc/BRIEF.md
# Depth Ordering Table Linker

This block keeps a depth-sorted list of primitive handles for a draw engine. A producer offers a handle together with a depth value. The block turns the depth into one of 256 bucket indices and links the handle onto the front of that bucket's chain. The chains live in a small link memory indexed by handle.

Two bucket tables alternate between two roles. One is being filled while the other is walked. A walk visits the buckets in order and streams every linked handle to the draw engine over a valid/ready port. In normal mode the walk goes from bucket 0 up to bucket 255, and a depth z lands in bucket 256 - z, so far primitives come out first. In reversed mode the depth input is used directly as the index, as when it comes from a reciprocal depth, and the walk goes from bucket 255 down to bucket 0.

A clear command empties the fill table one bucket per cycle. A swap command exchanges the two roles and starts the walk of the table that was just filled.

Top module: `depth_otable_linker`

## Requirements
- R1: After reset, `ins_ready_o` and `swap_ready_o` are 1, `out_valid_o` is 0, and both tables are empty.
- R2: With `rev_i`=0, an insert of depth z goes to bucket 256 - z. Depth 0 is clamped to bucket 255, and any depth of 256 or more is clamped to bucket 0.
- R3: With `rev_i`=1, an insert of depth z goes to bucket z. Any depth above 255 is clamped to bucket 255.
- R4: An insert prepends its handle to the chosen bucket, so within one bucket the most recently inserted handle is emitted first.
- R5: A walk emits its buckets in ascending index order if `rev_i` was 0 at the accepted swap, and in descending order if it was 1.
- R6: A clear is started by `clear_i` while no clear is running.
  - It holds `ins_ready_o` low for exactly 256 cycles, starting with the cycle after `clear_i`.
  - It empties the fill table, including any insert accepted in the same cycle as `clear_i`.
- R7: A swap is accepted only when all of these hold:
  - the previous walk has finished,
  - no clear is running,
  - `clear_i` is low.
  Otherwise `swap_ready_o` is 0. A swap offered together with `clear_i` waits until the clear ends.
- R8: Inserts made while a walk is running go to the other table. They do not appear in the running walk, and they are emitted by the walk that follows the next swap.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle keeps `out_valid_o` at 1 with `out_handle_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_i | input | 1 | Reversed mode: selects the index mapping at insert and the walk direction at swap |
| ins_valid_i | input | 1 | Insert request |
| ins_ready_o | output | 1 | Insert accepted when high (low while a clear runs) |
| ins_depth_i | input | DEPTH_W (10) | Depth value of the inserted primitive |
| ins_handle_i | input | HANDLE_W (6) | Handle of the inserted primitive |
| clear_i | input | 1 | Start emptying the fill table |
| swap_valid_i | input | 1 | Request to swap the tables and start a walk |
| swap_ready_o | output | 1 | Swap accepted when high |
| out_valid_o | output | 1 | Walk output handle valid |
| out_ready_i | input | 1 | Draw engine accepts the handle |
| out_handle_o | output | HANDLE_W (6) | Handle emitted by the walk |

## Verification
The hardest situations to reach are the ones where the three activities overlap: a walk under random backpressure, inserts into the other table during that walk, and a clear that stalls an insert while the walk continues. The stimulus reaches them in three steps:
- It inserts the second frame while the first frame is still draining.
- It fires a clear in the same cycle as an insert, and then offers another insert that must wait out the 256 stall cycles.
- It raises a swap in the same cycle as a clear, so the swap must wait for the clear to finish.

The reference model keeps one queue per bucket. It checks every emitted handle against the concatenated queues, and it checks both ready outputs on every cycle.

// File: rtl/otl_pkg.sv
package otl_pkg;
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_SCAN = 2'd1,
    W_EMIT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/otl_depth_map.sv
module otl_depth_map #(
  parameter int NUM_BUCKETS = 256,
  parameter int DEPTH_W     = 10,
  parameter int IDX_W       = $clog2(NUM_BUCKETS)
) (
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               rev_i,
  output logic [IDX_W-1:0]   idx_o
);
  localparam logic [DEPTH_W-1:0] N_D   = DEPTH_W'(NUM_BUCKETS);
  localparam logic [DEPTH_W-1:0] TOP_D = DEPTH_W'(NUM_BUCKETS - 1);

  logic [DEPTH_W-1:0] diff;
  assign diff = N_D - depth_i;

  always_comb begin
    if (rev_i) begin
      idx_o = (depth_i > TOP_D) ? IDX_W'(NUM_BUCKETS - 1) : depth_i[IDX_W-1:0];
    end else if (depth_i == '0) begin
      idx_o = IDX_W'(NUM_BUCKETS - 1);
    end else if (depth_i >= N_D) begin
      idx_o = '0;
    end else begin
      idx_o = diff[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/otl_head_table.sv
module otl_head_table #(
  parameter int NUM_BUCKETS = 256,
  parameter int HANDLE_W    = 6,
  parameter int IDX_W       = $clog2(NUM_BUCKETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fill_sel_i,
  input  logic                ins_we_i,
  input  logic [IDX_W-1:0]    ins_idx_i,
  input  logic [HANDLE_W-1:0] ins_handle_i,
  output logic                old_vld_o,
  output logic [HANDLE_W-1:0] old_head_o,
  input  logic                clear_start_i,
  output logic                clr_busy_o,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                rd_vld_o,
  output logic [HANDLE_W-1:0] rd_head_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUCKETS - 1);

  logic [HANDLE_W-1:0]    head_q [2][NUM_BUCKETS];
  logic [NUM_BUCKETS-1:0] hvld_q [2];
  logic                   clr_busy_q;
  logic [IDX_W-1:0]       clr_cnt_q;

  always_ff @(posedge clk_i) begin
    if (ins_we_i) head_q[fill_sel_i][ins_idx_i] <= ins_handle_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hvld_q[0] <= '0;
      hvld_q[1] <= '0;
    end else begin
      if (clr_busy_q) hvld_q[fill_sel_i][clr_cnt_q] <= 1'b0;
      if (ins_we_i)   hvld_q[fill_sel_i][ins_idx_i] <= 1'b1;
    end
  end

  // sequential wipe, one bucket per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_busy_q <= 1'b0;
      clr_cnt_q  <= '0;
    end else if (clr_busy_q) begin
      clr_cnt_q <= clr_cnt_q + 1'b1;
      if (clr_cnt_q == LAST_IDX) clr_busy_q <= 1'b0;
    end else if (clear_start_i) begin
      clr_busy_q <= 1'b1;
      clr_cnt_q  <= '0;
    end
  end

  assign clr_busy_o = clr_busy_q;
  assign old_vld_o  = hvld_q[fill_sel_i][ins_idx_i];
  assign old_head_o = head_q[fill_sel_i][ins_idx_i];
  assign rd_vld_o   = hvld_q[~fill_sel_i][rd_idx_i];
  assign rd_head_o  = head_q[~fill_sel_i][rd_idx_i];

  assert_insert_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_we_i |=> hvld_q[$past(fill_sel_i)][$past(ins_idx_i)]);

  assert_clear_wipes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_busy_q && clr_cnt_q == LAST_IDX) |=> (!clr_busy_q && hvld_q[$past(fill_sel_i)] == '0));

  assert_clear_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_busy_q) |-> $past(clear_start_i));
endmodule

// File: rtl/otl_link_ram.sv
module otl_link_ram #(
  parameter int HANDLE_W = 6,
  parameter int DEPTH    = 1 << HANDLE_W
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [HANDLE_W-1:0] waddr_i,
  input  logic                wvld_i,
  input  logic [HANDLE_W-1:0] wnext_i,
  input  logic [HANDLE_W-1:0] raddr_i,
  output logic                rvld_o,
  output logic [HANDLE_W-1:0] rnext_o
);
  logic [HANDLE_W:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= {wvld_i, wnext_i};
  end

  assign {rvld_o, rnext_o} = mem_q[raddr_i];
endmodule

// File: rtl/otl_walker.sv
module otl_walker import otl_pkg::*; #(
  parameter int NUM_BUCKETS = 256,
  parameter int HANDLE_W    = 6,
  parameter int IDX_W       = $clog2(NUM_BUCKETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                rev_i,
  output logic                idle_o,
  output logic [IDX_W-1:0]    cur_o,
  input  logic                head_vld_i,
  input  logic [HANDLE_W-1:0] head_i,
  output logic [HANDLE_W-1:0] node_o,
  input  logic                nxt_vld_i,
  input  logic [HANDLE_W-1:0] nxt_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [HANDLE_W-1:0] out_handle_o
);
  walk_st_e            state_q;
  logic [IDX_W-1:0]    cur_q;
  logic [HANDLE_W-1:0] node_q;
  logic                rev_q;
  logic                last;
  logic [IDX_W-1:0]    step;

  assign last = rev_q ? (cur_q == '0) : (cur_q == IDX_W'(NUM_BUCKETS - 1));
  assign step = rev_q ? cur_q - 1'b1 : cur_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      cur_q   <= '0;
      node_q  <= '0;
      rev_q   <= 1'b0;
    end else begin
      unique case (state_q)
        W_IDLE: if (start_i) begin
          state_q <= W_SCAN;
          rev_q   <= rev_i;
          cur_q   <= rev_i ? IDX_W'(NUM_BUCKETS - 1) : '0;
        end
        W_SCAN: begin
          if (head_vld_i) begin
            node_q  <= head_i;
            state_q <= W_EMIT;
          end else if (last) begin
            state_q <= W_IDLE;
          end else begin
            cur_q <= step;
          end
        end
        W_EMIT: if (out_ready_i) begin
          if (nxt_vld_i) begin
            node_q <= nxt_i;
          end else if (last) begin
            state_q <= W_IDLE;
          end else begin
            cur_q   <= step;
            state_q <= W_SCAN;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign idle_o       = (state_q == W_IDLE);
  assign cur_o        = cur_q;
  assign node_o       = node_q;
  assign out_valid_o  = (state_q == W_EMIT);
  assign out_handle_o = node_q;

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_handle_o)));

  assert_walk_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != W_IDLE) |=> (rev_q ? (cur_q <= $past(cur_q)) : (cur_q >= $past(cur_q))));
endmodule

// File: rtl/depth_otable_linker.sv
module depth_otable_linker #(
  parameter int NUM_BUCKETS = 256,
  parameter int HANDLE_W    = 6,
  parameter int DEPTH_W     = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rev_i,
  input  logic                ins_valid_i,
  output logic                ins_ready_o,
  input  logic [DEPTH_W-1:0]  ins_depth_i,
  input  logic [HANDLE_W-1:0] ins_handle_i,
  input  logic                clear_i,
  input  logic                swap_valid_i,
  output logic                swap_ready_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [HANDLE_W-1:0] out_handle_o
);
  localparam int IDX_W = $clog2(NUM_BUCKETS);

  logic                fill_sel_q;
  logic                clr_busy, walk_idle, ins_fire, swap_fire;
  logic [IDX_W-1:0]    ins_idx, cur;
  logic                old_vld, rd_vld, nxt_vld;
  logic [HANDLE_W-1:0] old_head, rd_head, node, nxt;

  assign ins_ready_o  = ~clr_busy;
  assign ins_fire     = ins_valid_i & ins_ready_o;
  assign swap_ready_o = walk_idle & ~clr_busy & ~clear_i;
  assign swap_fire    = swap_valid_i & swap_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fill_sel_q <= 1'b0;
    else if (swap_fire) fill_sel_q <= ~fill_sel_q;
  end

  otl_depth_map #(.NUM_BUCKETS(NUM_BUCKETS), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)) u_map (
    .depth_i(ins_depth_i), .rev_i(rev_i), .idx_o(ins_idx)
  );

  otl_head_table #(.NUM_BUCKETS(NUM_BUCKETS), .HANDLE_W(HANDLE_W), .IDX_W(IDX_W)) u_heads (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_sel_i(fill_sel_q),
    .ins_we_i(ins_fire), .ins_idx_i(ins_idx), .ins_handle_i(ins_handle_i),
    .old_vld_o(old_vld), .old_head_o(old_head),
    .clear_start_i(clear_i), .clr_busy_o(clr_busy),
    .rd_idx_i(cur), .rd_vld_o(rd_vld), .rd_head_o(rd_head)
  );

  otl_link_ram #(.HANDLE_W(HANDLE_W)) u_links (
    .clk_i(clk_i), .we_i(ins_fire), .waddr_i(ins_handle_i),
    .wvld_i(old_vld), .wnext_i(old_head),
    .raddr_i(node), .rvld_o(nxt_vld), .rnext_o(nxt)
  );

  otl_walker #(.NUM_BUCKETS(NUM_BUCKETS), .HANDLE_W(HANDLE_W), .IDX_W(IDX_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(swap_fire), .rev_i(rev_i),
    .idle_o(walk_idle), .cur_o(cur), .head_vld_i(rd_vld), .head_i(rd_head),
    .node_o(node), .nxt_vld_i(nxt_vld), .nxt_i(nxt),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_handle_o(out_handle_o)
  );

  assert_no_swap_midwalk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !swap_ready_o);

  assert_ins_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_ready_o && clear_i) |=> !ins_ready_o);
endmodule

// File: tb/sim_depth_otable_linker.sv
`timescale 1ns/1ps
module sim_depth_otable_linker;
  localparam int NB = 256;
  localparam int HW = 6;
  localparam int DW = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rev = 1'b0, ins_valid = 1'b0, clear = 1'b0, swap_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] ins_depth = '0;
  logic [HW-1:0] ins_handle = '0;
  logic ins_ready, swap_ready, out_valid;
  logic [HW-1:0] out_handle;

  always #10 clk = ~clk;

  depth_otable_linker #(.NUM_BUCKETS(NB), .HANDLE_W(HW), .DEPTH_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rev_i(rev),
    .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_depth_i(ins_depth), .ins_handle_i(ins_handle),
    .clear_i(clear), .swap_valid_i(swap_valid), .swap_ready_o(swap_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_handle_o(out_handle)
  );

  int n_chk = 0, n_err = 0;
  int mq[2][NB][$];
  int exp_q[$];
  int got[$];
  int fill = 0, busy_cnt = 0;
  string ph = "R5", next_ph = "R5";
  bit prev_hold = 0;
  int prev_h = 0;
  bit run_mon = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int bucket_of(input int z, input bit r);
    int b;
    if (r) b = (z > NB - 1) ? NB - 1 : z;
    else begin
      b = NB - z;
      if (b > NB - 1) b = NB - 1;
      if (b < 0) b = 0;
    end
    return b;
  endfunction

  function automatic int pos_of(input int h);
    foreach (got[i]) if (got[i] == h) return i;
    return -1;
  endfunction

  // reference model, evaluated at each negedge for the following posedge
  always @(negedge clk) begin
    if (run_mon && rst_ni) begin
      chk(ins_ready == (busy_cnt == 0), "R6 ins_ready", int'(ins_ready), int'(busy_cnt == 0));
      if (exp_q.size() > 0 || busy_cnt > 0 || clear)
        chk(swap_ready == 1'b0, "R7 swap_ready", int'(swap_ready), 0);
      if (exp_q.size() == 0)
        chk(out_valid == 1'b0, {ph, " out_valid with nothing pending"}, int'(out_valid), 0);
      if (prev_hold) begin
        chk(out_valid == 1'b1, "R9 valid held", int'(out_valid), 1);
        chk(int'(out_handle) == prev_h, "R9 handle held", int'(out_handle), prev_h);
      end
      prev_hold = out_valid && !out_ready;
      prev_h = int'(out_handle);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, {ph, " unexpected handle"}, int'(out_handle), -1);
        else begin
          chk(int'(out_handle) == exp_q[0], {ph, " R5 walk order"}, int'(out_handle), exp_q[0]);
          void'(exp_q.pop_front());
        end
        got.push_back(int'(out_handle));
      end
      if (busy_cnt > 0) busy_cnt--;
      if (ins_valid && ins_ready)
        mq[fill][bucket_of(int'(ins_depth), rev)].push_front(int'(ins_handle));
      if (clear && busy_cnt == 0 && ins_ready) begin
        for (int b = 0; b < NB; b++) mq[fill][b].delete();
        busy_cnt = NB;
      end
      if (swap_valid && swap_ready) begin
        int d;
        d = fill;
        fill ^= 1;
        ph = next_ph;
        got.delete();
        exp_q.delete();
        for (int i = 0; i < NB; i++) begin
          int b;
          b = rev ? NB - 1 - i : i;
          foreach (mq[d][b][k]) exp_q.push_back(mq[d][b][k]);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom_range(3) != 0);
    end
  end

  task automatic do_insert(input int z, input int h);
    ins_valid = 1'b1; ins_depth = DW'(z); ins_handle = HW'(h);
    do @(negedge clk); while (!ins_ready);
    @(posedge clk); #1;
    ins_valid = 1'b0;
  endtask

  task automatic do_swap(input string tag);
    next_ph = tag;
    swap_valid = 1'b1;
    do @(negedge clk); while (!swap_ready);
    @(posedge clk); #1;
    swap_valid = 1'b0;
  endtask

  task automatic wait_walk;
    do @(negedge clk); while (!(exp_q.size() == 0 && swap_ready));
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(ins_ready == 1'b1, "R1 ins_ready", int'(ins_ready), 1);
    chk(swap_ready == 1'b1, "R1 swap_ready", int'(swap_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    run_mon = 1;
    @(posedge clk); #1;

    // frame A, normal mode, clamp corners
    rev = 1'b0;
    do_insert(0, 0);
    do_insert(1023, 1);
    do_insert(257, 2);
    do_insert(256, 3);
    do_insert(100, 4);
    do_insert(200, 5);
    do_swap("R2");
    // frame B inserted into the other table while A drains
    do_insert(50, 16);
    do_insert(50, 17);
    do_insert(10, 18);
    do_insert(255, 19);
    wait_walk();
    chk(got.size() == 6, "R2 frame size", got.size(), 6);
    chk(got[5] == 0, "R2 depth 0 clamps to last bucket", got[5], 0);
    chk(got[0] == 3, "R4 last insert of bucket 0 first", got[0], 3);
    chk(pos_of(5) < pos_of(4), "R5 ascending buckets", pos_of(5), pos_of(4));

    do_swap("R8");
    // clear fill table with a same-cycle insert that must be wiped
    clear = 1'b1; ins_valid = 1'b1; ins_depth = DW'(3); ins_handle = HW'(20);
    @(posedge clk); #1;
    clear = 1'b0; ins_valid = 1'b0;
    rev = 1'b1;
    do_insert(7, 36);   // stalls through the clear
    do_insert(300, 32);
    do_insert(5, 33);
    do_insert(128, 34);
    do_insert(0, 35);
    wait_walk();
    chk(got.size() == 4, "R8 frame B size", got.size(), 4);
    chk(got[1] == 17 && got[2] == 16, "R4 same-depth order", got[1], 17);
    chk(got[0] == 19, "R8 first of frame B", got[0], 19);

    do_swap("R3");
    wait_walk();
    chk(got.size() == 5, "R6 wiped same-cycle insert", got.size(), 5);
    chk(pos_of(20) == -1, "R6 handle 20 absent", pos_of(20), -1);
    chk(got[0] == 32, "R3 depth 300 clamps to top bucket", got[0], 32);
    chk(got[4] == 35, "R5 descending ends at bucket 0", got[4], 35);
    chk(pos_of(34) < pos_of(36), "R3 direct index order", pos_of(34), pos_of(36));

    // swap offered together with clear must wait for the clear
    next_ph = "R6";
    swap_valid = 1'b1; clear = 1'b1;
    @(negedge clk);
    chk(swap_ready == 1'b0, "R7 swap blocked by clear", int'(swap_ready), 0);
    @(posedge clk); #1;
    clear = 1'b0;
    @(negedge clk);
    chk(swap_ready == 1'b0, "R7 swap blocked during clear", int'(swap_ready), 0);
    do @(negedge clk); while (!swap_ready);
    @(posedge clk); #1;
    swap_valid = 1'b0;
    repeat (300) @(posedge clk);
    #1;
    chk(got.size() == 0, "R6 cleared table emits nothing", got.size(), 0);
    chk(swap_ready == 1'b1, "R7 ready after empty walk", int'(swap_ready), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule